// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a free-running 64-bit time-of-day value whose unit is 2^-19 ns. Nineteen bits hold fractional nanoseconds and the 45 bits above them hold whole nanoseconds. Every P reference clock cycles it adds a programmable 24-bit step to the time. Software trims the clock rate by nudging the fractional part of that step. The nominal setting, P = 1 and step = 16 << 19, advances the time by exactly 16 ns on each reference tick.

Software reaches the block through a 32-bit register port with three words. Address 0 is the low half of the time and address 1 is the high half. Address 2 is the rate word: bits 31:24 are the period P and bits 23:0 are the step, which has 5 integer and 19 fraction bits.

The time is wider than the port, so both read and write are made coherent. A read of the low half latches the upper half into a shadow, and a later read of the high half returns the upper half that matched that low half. A write of the low half only stages the value. The following write of the high half loads all 64 bits in one cycle.

Top module: `frac_tod_timer`

## Requirements
- R1: After reset the time is 0 and the rate word reads 0, so the time stays at 0 until software writes a non-zero period.
- R2: The rate word at address 2 reads back exactly what was last written: period in bits 31:24, step in bits 23:0.
- R3: With period P > 0, the time grows by the step exactly once every P cycles and holds in between. The first add comes P cycles after the rate write.
- R4: A period of 0 freezes the time at its current value.
- R5: With period 1 and step 0x800000 (16 << 19), the whole-nanosecond part (time >> 19) grows by 16 each cycle.
- R6: A read of address 0 returns the live low half and latches the live high half. A later read of address 1 returns that latched high half, even if the counter has carried in between.
- R7: A write to address 0 only stages data and leaves the running time unchanged. A write to address 1 loads {written high, staged low} in that cycle, and the load wins over any add due in the same cycle.
- R8: The time wraps modulo 2^64 and keeps counting after the wrap.
- R9: Every write of the rate word restarts the period divider, so the next add comes P cycles after that write.
- R10: Address 3 reads as 0, and writes to it change neither the time nor the rate word.
- R11: Read data appears on reg_rdata one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 2 | Word address: 0 low, 1 high, 2 rate, 3 reserved |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| time_o | output | 64 | Live time value in 2^-19 ns units |

## Verification
The bench goes after three corner cases: a low/high read pair that straddles a carry out of the low word, a high-word load in a cycle where an add is also due, and a wrap past 2^64. A design that read the high half live would return the carried value instead of the latched one. One that let the add win would be off by one step right after a load. One that saturated would stop at the top. The bench also rewrites the rate word part way through a period. A divider that kept its old phase would add one step too early.

// File: rtl/frac_tod_pkg.sv
package frac_tod_pkg;
   typedef enum logic [1:0] {
      RA_LO  = 2'd0,
      RA_HI  = 2'd1,
      RA_INC = 2'd2,
      RA_RSV = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/frac_tod_divider.sv
module frac_tod_divider #(
   parameter int PER_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PER_W-1:0] period,
   input  logic             restart,
   output logic             tick
);
   logic [PER_W-1:0] phase_q;
   logic             at_end;

   // add fires when the phase has counted period-1 cycles since the last add
   assign at_end = (period != '0) && (phase_q == PER_W'(period - 1'b1));
   assign tick   = at_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (restart || at_end || period == '0) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end
endmodule

// File: rtl/frac_tod_accum.sv
module frac_tod_accum #(
   parameter int TIME_W = 64,
   parameter int INC_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TIME_W-1:0] load_val,
   input  logic              tick,
   input  logic [INC_W-1:0]  step,
   output logic [TIME_W-1:0] time_q
);
   localparam int PAD_W = TIME_W - INC_W;

   logic [TIME_W-1:0] step_ext;
   assign step_ext = {{PAD_W{1'b0}}, step};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         time_q <= '0;
      end else if (load) begin
         time_q <= load_val;
      end else if (tick) begin
         time_q <= time_q + step_ext;
      end
   end
endmodule

// File: rtl/frac_tod_regif.sv
module frac_tod_regif
   import frac_tod_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int TIME_W    = 64,
   parameter bit RDATA_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [TIME_W-1:0] time_now,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [DATA_W-1:0] rate_q,
   output logic [DATA_W-1:0] staged_lo,
   output logic [DATA_W-1:0] shadow_hi,
   output logic              load,
   output logic [TIME_W-1:0] load_val,
   output logic              rate_wr
);
   logic wr_lo, wr_hi, wr_rate, rd_lo;
   logic [DATA_W-1:0] rd_mux;

   assign wr_lo   = reg_wr && (reg_addr == RA_LO);
   assign wr_hi   = reg_wr && (reg_addr == RA_HI);
   assign wr_rate = reg_wr && (reg_addr == RA_INC);
   assign rd_lo   = reg_rd && (reg_addr == RA_LO);

   assign load     = wr_hi;
   assign load_val = {reg_wdata, staged_lo};
   assign rate_wr  = wr_rate;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q    <= '0;
         staged_lo <= '0;
         shadow_hi <= '0;
      end else begin
         if (wr_rate) rate_q    <= reg_wdata;
         if (wr_lo)   staged_lo <= reg_wdata;
         if (rd_lo)   shadow_hi <= time_now[TIME_W-1:DATA_W];
      end
   end

   always_comb begin
      unique case (reg_addr)
         RA_LO:   rd_mux = time_now[DATA_W-1:0];
         RA_HI:   rd_mux = shadow_hi;
         RA_INC:  rd_mux = rate_q;
         default: rd_mux = '0;
      endcase
   end

   generate
      if (RDATA_REG) begin : g_rd_flop
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      rdata_q <= '0;
            else if (reg_rd) rdata_q <= rd_mux;
         end
         assign reg_rdata = rdata_q;
      end else begin : g_rd_comb
         assign reg_rdata = reg_rd ? rd_mux : '0;
      end
   endgenerate
endmodule

// File: rtl/frac_tod_timer.sv
module frac_tod_timer
   import frac_tod_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int TIME_W    = 64,
   parameter int PER_W     = 8,
   parameter int FRAC_W    = 19,
   parameter bit RDATA_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [TIME_W-1:0] time_o
);
   localparam int INC_W = DATA_W - PER_W;

   generate
      if (TIME_W != 2 * DATA_W) begin : g_bad_time_w
         $error("TIME_W must be twice DATA_W");
      end
      if (PER_W < 1 || PER_W >= DATA_W) begin : g_bad_per_w
         $error("PER_W must lie inside the data word");
      end
      if (FRAC_W >= INC_W) begin : g_bad_frac_w
         $error("FRAC_W must leave integer bits in the step");
      end
   endgenerate

   logic [DATA_W-1:0] rate_q, staged_lo, shadow_hi;
   logic [TIME_W-1:0] load_val, time_q;
   logic              load, rate_wr, tick;

   frac_tod_regif #(
      .DATA_W(DATA_W), .TIME_W(TIME_W), .RDATA_REG(RDATA_REG)
   ) u_regif (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .time_now(time_q),
      .reg_rdata(reg_rdata), .rate_q(rate_q), .staged_lo(staged_lo),
      .shadow_hi(shadow_hi), .load(load), .load_val(load_val),
      .rate_wr(rate_wr)
   );

   frac_tod_divider #(.PER_W(PER_W)) u_div (
      .clk(clk), .rst_n(rst_n), .period(rate_q[DATA_W-1:INC_W]),
      .restart(rate_wr), .tick(tick)
   );

   frac_tod_accum #(.TIME_W(TIME_W), .INC_W(INC_W)) u_accum (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
      .tick(tick), .step(rate_q[INC_W-1:0]), .time_q(time_q)
   );

   assign time_o = time_q;
endmodule

// File: rtl/frac_tod_timer_chk.sv
module frac_tod_timer_chk #(
   parameter int DATA_W = 32,
   parameter int TIME_W = 64,
   parameter int PER_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [1:0]        reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [TIME_W-1:0] time_o,
   input logic [DATA_W-1:0] rate_q,
   input logic [DATA_W-1:0] staged_lo,
   input logic [DATA_W-1:0] shadow_hi
);
   localparam int INC_W = DATA_W - PER_W;

   // R7: a high-word write loads the staged low word with the written high word
   p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd1) |=> time_o == {$past(reg_wdata), $past(staged_lo)});

   // R3: without a load the time either holds or grows by exactly one step
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == 2'd1) |=>
         (time_o == $past(time_o)) ||
         (time_o == $past(time_o) + TIME_W'($past(rate_q[INC_W-1:0]))));

   // R4: a zero period with no write freezes the time
   p_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && rate_q[DATA_W-1:INC_W] == '0) |=> $stable(time_o));

   // R6: a low read latches the high half that was live at that edge
   p_snap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 2'd0) |=> shadow_hi == $past(time_o[TIME_W-1:DATA_W]));

   // R10: a write to the reserved address leaves the rate word alone
   p_rsv_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd3) |=> $stable(rate_q));
endmodule

bind frac_tod_timer frac_tod_timer_chk #(
   .DATA_W(DATA_W), .TIME_W(TIME_W), .PER_W(PER_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .time_o(time_o),
   .rate_q(rate_q), .staged_lo(staged_lo), .shadow_hi(shadow_hi)
);

// File: tb/frac_tod_timer_bench.sv
module frac_tod_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [63:0] time_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   frac_tod_timer u_frac_tod_timer (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .time_o(time_o)
   );

   // vector table: period, step, cycles waited, expected time
   localparam int NV = 6;
   localparam logic [7:0]  V_PER [NV] = '{8'd1, 8'd3, 8'd4, 8'd255, 8'd0, 8'd2};
   localparam logic [23:0] V_INC [NV] = '{24'h800000, 24'h000123, 24'hFFFFFF,
                                          24'h000005, 24'h000ABC, 24'h000001};
   localparam int          V_CYC [NV] = '{10, 10, 8, 300, 20, 7};
   localparam logic [63:0] V_EXP [NV] = '{64'h5000000, 64'h369, 64'h1FFFFFE,
                                          64'h5, 64'h0, 64'h3};

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic load_halted(input logic [63:0] v);
      wr(2'd2, 32'h0);
      wr(2'd0, v[31:0]);
      wr(2'd1, v[63:32]);
   endtask

   initial begin
      logic [31:0] d, lo_v, hi_v;
      logic [63:0] t0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state, and halted until a period is set
      check(time_o == 64'h0, "R1 time after reset", time_o, 64'h0);
      rd(2'd2, d);
      check(d == 32'h0, "R1 rate word after reset", {32'h0, d}, 64'h0);
      repeat (5) @(negedge clk);
      check(time_o == 64'h0, "R1 halted after reset", time_o, 64'h0);

      // R3 R4 R5: vector table
      for (int i = 0; i < NV; i++) begin
         load_halted(64'h0);
         wr(2'd2, {V_PER[i], V_INC[i]});
         repeat (V_CYC[i]) @(negedge clk);
         check(time_o == V_EXP[i], $sformatf("R3/R4 vector %0d", i), time_o, V_EXP[i]);
      end
      // R5: first vector is the nominal setting, 10 cycles -> 160 ns
      load_halted(64'h0);
      wr(2'd2, 32'h01800000);
      repeat (10) @(negedge clk);
      check((time_o >> 19) == 64'd160, "R5 nominal 16 ns per tick", time_o >> 19, 64'd160);

      // R2: rate word readback
      wr(2'd2, 32'h00ABCDEF);
      rd(2'd2, d);
      check(d == 32'h00ABCDEF, "R2 rate readback", {32'h0, d}, 64'h00ABCDEF);
      wr(2'd2, 32'h7F123456);
      rd(2'd2, d);
      check(d == 32'h7F123456, "R2 rate readback fields", {32'h0, d}, 64'h7F123456);

      // R6 R11: coherent read across a carry
      load_halted(64'h00000001_FFFFFFF0);
      wr(2'd2, {8'd1, 24'h10});
      rd(2'd0, lo_v);
      check(lo_v == 32'hFFFFFFF0, "R6 R11 low read", {32'h0, lo_v}, 64'hFFFFFFF0);
      rd(2'd1, hi_v);
      check(hi_v == 32'h1, "R6 latched high half", {32'h0, hi_v}, 64'h1);
      check(time_o[63:32] == 32'h2, "R6 live counter carried", time_o, 64'h2_00000000);

      // R7: staging leaves time running; load wins over add
      load_halted(64'h0);
      wr(2'd2, {8'd1, 24'h100});
      t0 = time_o;
      wr(2'd0, 32'hCAFE0000);
      check(time_o == t0 + 64'h100, "R7 low write only stages", time_o, t0 + 64'h100);
      wr(2'd1, 32'h12345678);
      check(time_o == 64'h12345678_CAFE0000, "R7 load wins", time_o, 64'h12345678_CAFE0000);
      @(negedge clk);
      check(time_o == 64'h12345678_CAFE0100, "R7 counts after load", time_o,
            64'h12345678_CAFE0100);

      // R8: wrap modulo 2^64
      load_halted(64'hFFFFFFFF_FFFFFFF0);
      wr(2'd2, {8'd1, 24'h20});
      @(negedge clk);
      check(time_o == 64'h10, "R8 wrap", time_o, 64'h10);
      @(negedge clk);
      check(time_o == 64'h30, "R8 counts after wrap", time_o, 64'h30);

      // R9: rewriting the rate word restarts the divider phase
      load_halted(64'h0);
      wr(2'd2, {8'd4, 24'h1});
      repeat (2) @(negedge clk);
      wr(2'd2, {8'd4, 24'h1});
      repeat (3) @(negedge clk);
      check(time_o == 64'h0, "R9 no early add", time_o, 64'h0);
      @(negedge clk);
      check(time_o == 64'h1, "R9 add after full period", time_o, 64'h1);

      // R10: reserved address
      load_halted(64'h55);
      wr(2'd3, 32'h01FFFFFF);
      rd(2'd3, d);
      check(d == 32'h0, "R10 reserved reads zero", {32'h0, d}, 64'h0);
      rd(2'd2, d);
      check(d == 32'h0, "R10 rate untouched", {32'h0, d}, 64'h0);
      check(time_o == 64'h55, "R10 time untouched", time_o, 64'h55);

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule